// File: doc/BRIEF.md
# DRAM Refresh Request Scheduler

This block keeps time for a DRAM controller. It asks the command arbiter for a periodic auto-refresh, and lets refreshes be postponed up to a bounded count. While a refresh is running it marks a blackout window in which no other command may start. It also controls self-refresh. It accepts entry and exit requests, and after an exit it reports two separate ready flags: one for read commands and one for all other commands. Each flag comes out of its own recovery delay.

Every interval is a parameter. Nanosecond values are turned into whole clock cycles by rounding up against `CLK_PERIOD_PS`. With the defaults and a 20 ns clock this gives:

- a refresh period of 390 cycles (7.8 us, which is 8192 refreshes per 64 ms);
- a blackout of 6 cycles (120 ns);
- a non-read exit delay of 4 cycles (75 ns);
- a read exit delay of 200 cycles, which is given directly in cycles.

The arbiter treats `ref_req` as an offer. A refresh counts as issued only in a cycle where both `ref_grant` and `ref_req` are high. A grant in any other cycle has no effect.

Top module: `refresh_sched`

## Requirements
- R1: After reset, `ref_req` rises once `REF_INTERVAL` cycles have elapsed. Each accepted grant restarts the interval, so the next request appears `REF_INTERVAL` cycles after the grant edge.
- R2: Each elapsed interval without a grant adds one to a postponed-refresh count, and each accepted grant removes one. The count saturates at `MAX_DEBT` (8). `ref_urgent` is high exactly when the count equals `MAX_DEBT`. Once `MAX_DEBT` grants have been accepted from saturation, `ref_req` is low.
- R3: An accepted grant (`ref_grant` and `ref_req` both high at a clock edge) drives `ref_busy` high for exactly `BLACKOUT` cycles (6 by default), starting the cycle after that edge.
- R4: `ref_req` is low whenever `ref_busy` is high.
- R5: `ref_req` is high only while `banks_idle` is high.
- R6: A grant that arrives while `ref_req` is low is ignored. `ref_busy` stays low and the postponed count is unchanged.
- R7: `sr_enter_req` is accepted only when `banks_idle` is high, the block is not busy, self-refresh is not already active and the non-read exit delay has expired. On acceptance `sr_active` goes high on the next cycle.
- R8: While `sr_active` is high, `ref_req` and `ref_urgent` stay low, the postponed count is cleared, and the interval timer does not advance.
- R9: On an accepted `sr_exit_req`, `sr_active` falls. `rdy_nonread` then rises `EXIT_NR` cycles (4 by default) after the exit edge, and `rdy_read` rises `SR_EXIT_RD_CYC` cycles (200) after it. Both flags are low while self-refresh is active.
- R10: In reset, and right after it: `ref_req`, `ref_urgent`, `ref_busy` and `sr_active` are low, and `rdy_nonread` and `rdy_read` are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_grant | input | 1 | Arbiter issues the offered refresh |
| banks_idle | input | 1 | All banks are precharged |
| sr_enter_req | input | 1 | Request to enter self-refresh |
| sr_exit_req | input | 1 | Request to leave self-refresh |
| ref_req | output | 1 | Refresh is owed and may be issued now |
| ref_urgent | output | 1 | Postponed count has reached its limit |
| ref_busy | output | 1 | Post-refresh blackout window |
| sr_active | output | 1 | Self-refresh is in progress |
| rdy_nonread | output | 1 | Non-read commands allowed after exit |
| rdy_read | output | 1 | Read commands allowed after exit |

## Verification
The properties assume the arbiter is well behaved, in three ways:

- `sr_enter_req` and `ref_grant` are never raised in the same cycle. The urgency-hold property depends on this.
- `banks_idle` is driven by the controller and not derived from this block.
- A grant may be raised while no request is offered. Such a grant is tolerated and must leave no trace.

The stimulus changes inputs only at falling edges and holds each request for exactly one rising edge. It never combines a grant with a self-refresh request. It deliberately issues one stray grant while `banks_idle` is low, to confirm that the grant is ignored.

// File: rtl/refresh_sched_pkg.sv
`timescale 1ns/1ps
package refresh_sched_pkg;
  // Round a nanosecond time up to a whole number of clock cycles.
  function automatic int ns_to_cycles(input int t_ns, input int period_ps);
    return (t_ns * 1000 + period_ps - 1) / period_ps;
  endfunction
endpackage

// File: rtl/refresh_interval.sv
`timescale 1ns/1ps
module refresh_interval #(
  parameter int INTERVAL = 390,
  parameter int MAX_DEBT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic grant,
  output logic owed,
  output logic full
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam int DW = $clog2(MAX_DEBT + 1);
  localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);
  localparam logic [DW-1:0] LIMIT  = DW'(MAX_DEBT);

  logic [CW-1:0] cnt;
  logic [DW-1:0] debt;
  logic          tick;

  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      cnt  <= RELOAD;
      debt <= '0;
    end else begin
      cnt <= (grant || tick) ? RELOAD : cnt - CW'(1);
      case ({tick, grant})
        2'b10: if (debt != LIMIT) debt <= debt + DW'(1);
        2'b01: debt <= debt - DW'(1);
        default: debt <= debt;
      endcase
    end
  end

  assign owed = (debt != '0);
  assign full = (debt == LIMIT);
endmodule

// File: rtl/hold_window.sv
`timescale 1ns/1ps
module hold_window #(
  parameter int CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int W = $clog2(CYCLES + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (start)        cnt <= W'(CYCLES);
    else if (cnt != '0)    cnt <= cnt - W'(1);
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/refresh_sched.sv
`timescale 1ns/1ps
module refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int CLK_PERIOD_PS   = 20000,
  parameter int REF_INTERVAL_NS = 7800,
  parameter int REF_BLACKOUT_NS = 120,
  parameter int SR_EXIT_NS      = 75,
  parameter int SR_EXIT_RD_CYC  = 200,
  parameter int MAX_DEBT        = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_grant,
  input  logic banks_idle,
  input  logic sr_enter_req,
  input  logic sr_exit_req,
  output logic ref_req,
  output logic ref_urgent,
  output logic ref_busy,
  output logic sr_active,
  output logic rdy_nonread,
  output logic rdy_read
);
  localparam int REF_INTERVAL = ns_to_cycles(REF_INTERVAL_NS, CLK_PERIOD_PS);
  localparam int BLACKOUT     = ns_to_cycles(REF_BLACKOUT_NS, CLK_PERIOD_PS);
  localparam int EXIT_NR      = ns_to_cycles(SR_EXIT_NS, CLK_PERIOD_PS);

  logic owed, full, grant_acc, enter_acc, exit_acc;
  logic nr_wait, rd_wait;

  refresh_interval #(.INTERVAL(REF_INTERVAL), .MAX_DEBT(MAX_DEBT)) u_interval (
    .clk(clk), .rst_n(rst_n), .hold(sr_active), .grant(grant_acc),
    .owed(owed), .full(full)
  );

  hold_window #(.CYCLES(BLACKOUT)) u_blackout (
    .clk(clk), .rst_n(rst_n), .start(grant_acc), .active(ref_busy)
  );

  hold_window #(.CYCLES(EXIT_NR)) u_exit_nr (
    .clk(clk), .rst_n(rst_n), .start(exit_acc), .active(nr_wait)
  );

  hold_window #(.CYCLES(SR_EXIT_RD_CYC)) u_exit_rd (
    .clk(clk), .rst_n(rst_n), .start(exit_acc), .active(rd_wait)
  );

  assign rdy_nonread = !sr_active && !nr_wait;
  assign rdy_read    = !sr_active && !rd_wait;

  // Self-refresh entry wins over a refresh offer in the same cycle.
  assign enter_acc = sr_enter_req && banks_idle && !ref_busy && rdy_nonread;
  assign exit_acc  = sr_exit_req && sr_active;
  assign ref_req   = owed && banks_idle && !ref_busy && rdy_nonread && !sr_enter_req;
  assign grant_acc = ref_grant && ref_req;
  assign ref_urgent = full && !sr_active;

  always_ff @(posedge clk) begin
    if (!rst_n)         sr_active <= 1'b0;
    else if (enter_acc) sr_active <= 1'b1;
    else if (exit_acc)  sr_active <= 1'b0;
  end
endmodule

// File: rtl/refresh_sched_chk.sv
`timescale 1ns/1ps
module refresh_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_grant,
  input logic banks_idle,
  input logic sr_enter_req,
  input logic ref_req,
  input logic ref_urgent,
  input logic ref_busy,
  input logic sr_active,
  input logic rdy_nonread,
  input logic rdy_read
);
  AST_BUSY_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_grant && ref_req) |=> ref_busy); // R3
  AST_NO_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ref_busy |-> !ref_req); // R4
  AST_REQ_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> banks_idle); // R5
  AST_URGENT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_urgent && !ref_grant && !sr_enter_req) |=> ref_urgent); // R2
  AST_SR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sr_active |-> (!ref_req && !ref_urgent)); // R8
  AST_EXIT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_active) |-> (!rdy_nonread && !rdy_read)); // R9
  AST_READ_AFTER_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_read |-> rdy_nonread); // R9
endmodule

bind refresh_sched refresh_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_grant(ref_grant), .banks_idle(banks_idle),
  .sr_enter_req(sr_enter_req), .ref_req(ref_req), .ref_urgent(ref_urgent),
  .ref_busy(ref_busy), .sr_active(sr_active), .rdy_nonread(rdy_nonread),
  .rdy_read(rdy_read)
);

// File: tb/refresh_sched_tb.sv
`timescale 1ns/1ps
module refresh_sched_tb;
  localparam int CLK_PS   = 20000;
  localparam int T_INT    = (7800 * 1000 + CLK_PS - 1) / CLK_PS;   // 390
  localparam int T_BLK    = (120 * 1000 + CLK_PS - 1) / CLK_PS;    // 6
  localparam int T_XNR    = (75 * 1000 + CLK_PS - 1) / CLK_PS;     // 4
  localparam int T_XRD    = 200;
  localparam int N_DEBT   = 8;
  // offset after exit edge, expected rdy_nonread, expected rdy_read
  localparam int EXIT_TAB [7][3] = '{
    '{0, 0, 0}, '{T_XNR-1, 0, 0}, '{T_XNR, 1, 0}, '{10, 1, 0},
    '{T_XRD-1, 1, 0}, '{T_XRD, 1, 1}, '{250, 1, 1}};

  logic clk = 0, rst_n = 0;
  logic ref_grant = 0, banks_idle = 1, sr_enter_req = 0, sr_exit_req = 0;
  logic ref_req, ref_urgent, ref_busy, sr_active, rdy_nonread, rdy_read;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  refresh_sched u_dut (
    .clk(clk), .rst_n(rst_n), .ref_grant(ref_grant), .banks_idle(banks_idle),
    .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .ref_busy(ref_busy), .sr_active(sr_active),
    .rdy_nonread(rdy_nonread), .rdy_read(rdy_read)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wait_req(output int n);
    n = 0;
    while (!ref_req && n < 5000) begin step(); n++; end
  endtask

  task automatic grant_once();
    ref_grant = 1; step(); ref_grant = 0;
  endtask

  initial begin
    int n, g, busy_len, j;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 ref_req", ref_req, 0);
    check("R10 ref_urgent", ref_urgent, 0);
    check("R10 ref_busy", ref_busy, 0);
    check("R10 sr_active", sr_active, 0);
    check("R10 rdy_nonread", rdy_nonread, 1);
    check("R10 rdy_read", rdy_read, 1);
    rst_n = 1;
    // R1 first request
    n = 0;
    while (!ref_req && n < 5000) begin step(); n++; end
    check("R1 first interval", n, T_INT);
    // R5 banks busy masks request; R6 stray grant ignored
    banks_idle = 0; #1;
    check("R5 req masked", ref_req, 0);
    grant_once();
    check("R6 busy after stray grant", ref_busy, 0);
    banks_idle = 1; #1;
    check("R6 debt kept", ref_req, 1);
    // R3 accepted grant and blackout length
    grant_once();
    g = cyc;
    check("R4 req low while busy", ref_req, 0);
    busy_len = 0;
    while (ref_busy && busy_len < 100) begin busy_len++; step(); end
    check("R3 blackout length", busy_len, T_BLK);
    check("R2 debt drained", ref_req, 0);
    // R1 restart after grant
    wait_req(n);
    check("R1 interval after grant", cyc - g, T_INT);
    // R2 saturation and urgency
    while (!ref_urgent && (cyc - g) < 6000) step();
    check("R2 urgent time", cyc - g, N_DEBT * T_INT);
    repeat (2 * T_INT) step();
    check("R2 urgent held", ref_urgent, 1);
    grant_once();
    check("R2 urgent clears", ref_urgent, 0);
    for (int k = 1; k < N_DEBT; k++) begin
      while (!ref_req) step();
      grant_once();
    end
    while (ref_busy) step();
    check("R2 saturated debt drained", ref_req, 0);
    // R7 entry refused when banks not idle
    wait_req(n);
    banks_idle = 0; sr_enter_req = 1; step(); sr_enter_req = 0; banks_idle = 1;
    check("R7 entry refused", sr_active, 0);
    sr_enter_req = 1; step(); sr_enter_req = 0;
    check("R7 entry taken", sr_active, 1);
    check("R8 req suppressed", ref_req, 0);
    check("R9 not ready in sr", rdy_nonread + rdy_read, 0);
    repeat (N_DEBT * T_INT + 10) step();
    check("R8 no urgency in sr", ref_urgent, 0);
    check("R8 no request in sr", ref_req, 0);
    // R9 exit delays, table walk
    sr_exit_req = 1; step(); sr_exit_req = 0;
    j = 0;
    foreach (EXIT_TAB[i]) begin
      while (j < EXIT_TAB[i][0]) begin step(); j++; end
      check("R9 rdy_nonread", rdy_nonread, EXIT_TAB[i][1]);
      check("R9 rdy_read", rdy_read, EXIT_TAB[i][2]);
    end
    check("R8 debt cleared", ref_req, 0);
    check("R8 sr left", sr_active, 0);
    done = 1;
  end

  initial begin
    while (!done && cyc < 100000) @(negedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule